// File: doc/BRIEF.md
# Floppy Drive Head Position and Media-Change Tracker

This block follows the state of one floppy drive: which cylinder the head sits on, which head is selected, and whether the medium may have changed since software last looked. A command sequencer hands it seek requests. A request is either an absolute cylinder or a relative move of N cylinders inward or outward. The block walks the head one cylinder per clock toward the clamped target. It emits a one-cycle step pulse with a direction for each cylinder it crosses, and a one-cycle completion strobe once the head is on target.

Media insert and eject arrive as single-cycle event inputs. The media-change flag is set at power-up, since the drive starts empty, and again on every eject. Inserting a disk does not clear it, and neither does looking at it. Only a real step made while a disk is present clears it. The flag is presented as bit 7 of an 8-bit status byte that the host register decoder returns on its input-status read.

Top module: `drive_seek_tracker`

## Requirements
- R1: After synchronous reset, `cur_cyl` is 0, `cur_head` is 0, `busy`, `step_pulse` and `seek_done` are 0, and `dir_reg` reads 0x80.
- R2: With no medium present, the change flag (bit 7 of `dir_reg`) stays 1 on every observation, including after seeks that step.
- R3: `dir_reg` bits 6..0 are always 0 and bit 7 carries the change flag. There is no read strobe, so observing the byte cannot alter the flag.
- R4: After an insert event the flag stays 1 until a step occurs. A seek to the cylinder the head already occupies issues no step pulse and leaves the flag at 1.
- R5: A seek that moves the head while a medium is present clears the flag. The clear takes effect on the clock edge after the first step pulse.
- R6: An eject event sets the flag on the next edge, and it stays 1 through later seeks, including ones that step.
- R7: `req_kind` 2'b00 (or 2'b11) means absolute target `req_arg`, 2'b01 means relative inward (`cur_cyl + req_arg`), and 2'b10 means relative outward (`cur_cyl - req_arg`). From cylinder 0, inward by 1 gives 1, and then outward by 1 gives 0.
- R8: Targets saturate at 0 when moving outward and at `MAX_CYL` (default 79) when moving inward or when an absolute target exceeds it. `cur_cyl` never exceeds `MAX_CYL`.
- R9: A seek accepted at edge E issues exactly |target − start| step pulses, one per edge on edges E+1 through E+d. Each pulse moves `cur_cyl` by one in the direction shown by `step_dir` (1 = inward). `seek_done` is high for one cycle after edge E+d+1, and `busy` drops on that same edge.
- R10: A request presented while `busy` is high is ignored. Target, head and step count of the running seek are unchanged.
- R11: `cur_head` takes the value of `req_head` at the acceptance edge and holds it while busy.
- R12: If an eject and a step coincide at the same edge, the eject wins and the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Seek request, accepted when idle |
| req_kind | input | 2 | Seek kind: 00/11 absolute, 01 inward, 10 outward |
| req_arg | input | CYL_W | Absolute cylinder or relative distance |
| req_head | input | 1 | Head to select |
| media_insert | input | 1 | One-cycle insert event |
| media_eject | input | 1 | One-cycle eject event |
| busy | output | 1 | Seek in progress |
| step_pulse | output | 1 | One-cycle step strobe |
| step_dir | output | 1 | Direction of latest step, 1 = inward |
| seek_done | output | 1 | One-cycle seek completion strobe |
| cur_cyl | output | CYL_W | Present cylinder |
| cur_head | output | 1 | Selected head |
| dir_reg | output | 8 | Input-status byte, bit 7 = change flag |

## Verification
Every result is registered. The head moves and the step pulse appears one edge after the previous step, the first step comes one edge after acceptance, and the completion strobe comes one edge after the last step. The change flag follows its cause by one more edge. The directed tests change inputs on the falling clock edge and sample on the next falling edge after each rising edge, counting edges from acceptance. They check that step k appears in cycle k and that completion appears in cycle d+1, not merely at some later point. Flag checks are taken only after the completion strobe or after the event's own edge, so that the one-cycle lag of the clear has already elapsed.

// File: rtl/seek_pkg.sv
package seek_pkg;

    // Kind of positioning request
    typedef enum logic [1:0] {
        SK_ABS  = 2'b00,
        SK_IN   = 2'b01,
        SK_OUT  = 2'b10,
        SK_ABS2 = 2'b11
    } seek_kind_e;

    // Head mover state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MOVE = 1'b1
    } mover_state_e;

    localparam int STATUS_W = 8;
    localparam int CHG_BIT  = 7;

endpackage

// File: rtl/seek_target_calc.sv
module seek_target_calc
    import seek_pkg::*;
#(
    parameter int CYL_W   = 8,
    parameter int MAX_CYL = 79
) (
    input  logic [1:0]       kind,
    input  logic [CYL_W-1:0] arg,
    input  logic [CYL_W-1:0] cur,
    output logic [CYL_W-1:0] tgt
);
    localparam logic [CYL_W-1:0] LIMIT = CYL_W'(MAX_CYL);

    logic [CYL_W:0] wide_sum;

    always_comb begin
        wide_sum = {1'b0, cur} + {1'b0, arg};
        unique case (seek_kind_e'(kind))
            SK_IN:   tgt = (wide_sum > {1'b0, LIMIT}) ? LIMIT : wide_sum[CYL_W-1:0];
            SK_OUT:  tgt = (arg > cur) ? '0 : (cur - arg);
            default: tgt = (arg > LIMIT) ? LIMIT : arg;
        endcase
    end
endmodule

// File: rtl/head_stepper.sv
module head_stepper
    import seek_pkg::*;
#(
    parameter int CYL_W   = 8,
    parameter int MAX_CYL = 79
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic [CYL_W-1:0] req_arg,
    input  logic             req_head,
    output logic             busy,
    output logic             step_pulse,
    output logic             step_dir,
    output logic             seek_done,
    output logic [CYL_W-1:0] cur_cyl,
    output logic             cur_head
);
    mover_state_e     state;
    logic [CYL_W-1:0] tgt_cyl;
    logic [CYL_W-1:0] next_tgt;

    seek_target_calc #(.CYL_W(CYL_W), .MAX_CYL(MAX_CYL)) u_calc (
        .kind (req_kind),
        .arg  (req_arg),
        .cur  (cur_cyl),
        .tgt  (next_tgt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur_cyl    <= '0;
            tgt_cyl    <= '0;
            cur_head   <= 1'b0;
            step_pulse <= 1'b0;
            step_dir   <= 1'b0;
            seek_done  <= 1'b0;
        end else begin
            step_pulse <= 1'b0;
            seek_done  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        tgt_cyl  <= next_tgt;
                        cur_head <= req_head;
                        state    <= ST_MOVE;
                    end
                end
                ST_MOVE: begin
                    if (cur_cyl == tgt_cyl) begin
                        seek_done <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (tgt_cyl > cur_cyl) begin
                        cur_cyl    <= cur_cyl + 1'b1;
                        step_pulse <= 1'b1;
                        step_dir   <= 1'b1;
                    end else begin
                        cur_cyl    <= cur_cyl - 1'b1;
                        step_pulse <= 1'b1;
                        step_dir   <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state == ST_MOVE);
endmodule

// File: rtl/change_latch.sv
module change_latch (
    input  logic clk,
    input  logic rst,
    input  logic media_insert,
    input  logic media_eject,
    input  logic stepped,
    output logic changed
);
    logic media_present;

    always_ff @(posedge clk) begin
        if (rst) begin
            media_present <= 1'b0;
            changed       <= 1'b1;
        end else if (media_eject) begin
            media_present <= 1'b0;
            changed       <= 1'b1;
        end else begin
            if (media_insert) begin
                media_present <= 1'b1;
            end
            if (stepped && media_present) begin
                changed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/drive_seek_tracker.sv
module drive_seek_tracker
    import seek_pkg::*;
#(
    parameter int CYL_W   = 8,
    parameter int MAX_CYL = 79
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [CYL_W-1:0]    req_arg,
    input  logic                req_head,
    input  logic                media_insert,
    input  logic                media_eject,
    output logic                busy,
    output logic                step_pulse,
    output logic                step_dir,
    output logic                seek_done,
    output logic [CYL_W-1:0]    cur_cyl,
    output logic                cur_head,
    output logic [STATUS_W-1:0] dir_reg
);
    logic chg_flag;

    head_stepper #(.CYL_W(CYL_W), .MAX_CYL(MAX_CYL)) u_step (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_arg    (req_arg),
        .req_head   (req_head),
        .busy       (busy),
        .step_pulse (step_pulse),
        .step_dir   (step_dir),
        .seek_done  (seek_done),
        .cur_cyl    (cur_cyl),
        .cur_head   (cur_head)
    );

    change_latch u_chg (
        .clk          (clk),
        .rst          (rst),
        .media_insert (media_insert),
        .media_eject  (media_eject),
        .stepped      (step_pulse),
        .changed      (chg_flag)
    );

    always_comb begin
        dir_reg          = '0;
        dir_reg[CHG_BIT] = chg_flag;
    end
endmodule

// File: rtl/seek_tracker_checker.sv
module seek_tracker_checker #(
    parameter int CYL_W   = 8,
    parameter int MAX_CYL = 79
) (
    input logic             clk,
    input logic             rst,
    input logic             media_eject,
    input logic             busy,
    input logic             step_pulse,
    input logic             step_dir,
    input logic             seek_done,
    input logic [CYL_W-1:0] cur_cyl,
    input logic             cur_head,
    input logic [7:0]       dir_reg
);
    AST_CYL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cur_cyl <= CYL_W'(MAX_CYL)); // R8

    AST_STEP_MOVES_ONE: assert property (@(posedge clk) disable iff (rst)
        step_pulse |-> (step_dir ? (cur_cyl == $past(cur_cyl) + 1'b1)
                                 : (cur_cyl == $past(cur_cyl) - 1'b1))); // R9

    AST_STEP_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(step_pulse && seek_done)); // R9

    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !step_pulse); // R9

    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        dir_reg[6:0] == 7'd0); // R3

    AST_EJECT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        $past(media_eject) |-> dir_reg[7]); // R6

    AST_CLEAR_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
        $fell(dir_reg[7]) |-> $past(step_pulse)); // R5

    AST_HEAD_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cur_head)); // R11
endmodule

bind drive_seek_tracker seek_tracker_checker #(.CYL_W(CYL_W), .MAX_CYL(MAX_CYL)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .media_eject (media_eject),
    .busy        (busy),
    .step_pulse  (step_pulse),
    .step_dir    (step_dir),
    .seek_done   (seek_done),
    .cur_cyl     (cur_cyl),
    .cur_head    (cur_head),
    .dir_reg     (dir_reg)
);

// File: tb/sim_drive_seek_tracker.sv
`timescale 1ns/1ps
module sim_drive_seek_tracker;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic [CW-1:0] req_arg = '0;
    logic          req_head = 1'b0;
    logic          media_insert = 1'b0;
    logic          media_eject = 1'b0;
    logic          busy, step_pulse, step_dir, seek_done, cur_head;
    logic [CW-1:0] cur_cyl;
    logic [7:0]    dir_reg;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    drive_seek_tracker #(.CYL_W(CW), .MAX_CYL(79)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_arg(req_arg), .req_head(req_head), .media_insert(media_insert),
        .media_eject(media_eject), .busy(busy), .step_pulse(step_pulse),
        .step_dir(step_dir), .seek_done(seek_done), .cur_cyl(cur_cyl),
        .cur_head(cur_head), .dir_reg(dir_reg)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic pulse_media(input bit ins);
        @(negedge clk);
        if (ins) media_insert = 1'b1; else media_eject = 1'b1;
        @(posedge clk);
        @(negedge clk);
        media_insert = 1'b0;
        media_eject  = 1'b0;
    endtask

    task automatic do_seek(input logic [1:0] kind, input int arg, input logic hd,
                           input int exp_cyl, input int exp_steps, input logic exp_dir,
                           input string rq);
        int  steps = 0;
        int  done_at = -1;
        int  late = 0;
        int  bad_dir = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_arg = CW'(arg); req_head = hd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= 300; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (step_pulse) begin
                steps++;
                if (k > exp_steps) late++;
                if (step_dir != exp_dir) bad_dir++;
            end
            if (seek_done) begin
                done_at = k;
                break;
            end
        end
        chk(rq, "R9 completion cycle", done_at, exp_steps + 1);
        chk(rq, "R9 step count", steps, exp_steps);
        chk(rq, "R9 steps out of window", late, 0);
        if (exp_steps > 0) chk(rq, "R9 step direction", bad_dir, 0);
        chk(rq, "cylinder", int'(cur_cyl), exp_cyl);
        chk("R11", "head", int'(cur_head), int'(hd));
        chk("R9", "busy after done", int'(busy), 0);
    endtask

    task automatic t_reset;
        chk("R1", "cur_cyl", int'(cur_cyl), 0);
        chk("R1", "cur_head", int'(cur_head), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "step/done", int'(step_pulse) + int'(seek_done), 0);
        chk("R1", "dir_reg", int'(dir_reg), 8'h80);
    endtask

    task automatic t_no_media;
        chk("R2", "flag read 1", int'(dir_reg[7]), 1);
        @(negedge clk);
        chk("R2", "flag read 2", int'(dir_reg[7]), 1);
        do_seek(2'b00, 1, 1'b0, 1, 1, 1'b1, "R2");
        chk("R2", "flag after step, empty", int'(dir_reg[7]), 1);
        chk("R3", "low bits", int'(dir_reg[6:0]), 0);
    endtask

    task automatic t_insert;
        pulse_media(1'b1);
        chk("R4", "flag after insert", int'(dir_reg[7]), 1);
        do_seek(2'b00, 1, 1'b0, 1, 0, 1'b1, "R4");
        chk("R4", "flag after no-step seek", int'(dir_reg[7]), 1);
        do_seek(2'b00, 2, 1'b0, 2, 1, 1'b1, "R5");
        chk("R5", "flag after step", int'(dir_reg[7]), 0);
    endtask

    task automatic t_eject;
        pulse_media(1'b0);
        chk("R6", "flag after eject", int'(dir_reg[7]), 1);
        do_seek(2'b00, 5, 1'b0, 5, 3, 1'b1, "R6");
        chk("R6", "flag after stepping seek", int'(dir_reg[7]), 1);
    endtask

    task automatic t_relative;
        pulse_media(1'b1);
        do_seek(2'b00, 0, 1'b0, 0, 5, 1'b0, "R5");
        chk("R5", "flag after outward steps", int'(dir_reg[7]), 0);
        do_seek(2'b01, 1, 1'b0, 1, 1, 1'b1, "R7");
        do_seek(2'b10, 1, 1'b0, 0, 1, 1'b0, "R7");
        do_seek(2'b11, 3, 1'b0, 3, 3, 1'b1, "R7");
        do_seek(2'b10, 3, 1'b0, 0, 3, 1'b0, "R7");
    endtask

    task automatic t_saturate;
        do_seek(2'b10, 3, 1'b0, 0, 0, 1'b0, "R8");
        do_seek(2'b00, 200, 1'b0, 79, 79, 1'b1, "R8");
        do_seek(2'b01, 5, 1'b0, 79, 0, 1'b1, "R8");
    endtask

    task automatic t_busy;
        int steps = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b00; req_arg = CW'(70); req_head = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_kind = 2'b00; req_arg = CW'(0); req_head = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (step_pulse) steps++;
        for (int k = 0; k < 300; k++) begin
            if (seek_done) break;
            @(posedge clk);
            @(negedge clk);
            if (step_pulse) steps++;
        end
        chk("R10", "cylinder", int'(cur_cyl), 70);
        chk("R10", "step count", steps, 9);
        chk("R11", "head kept", int'(cur_head), 1);
    endtask

    task automatic t_race;
        int guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b00; req_arg = CW'(74); req_head = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        media_eject = 1'b1;
        @(posedge clk);
        @(negedge clk);
        media_eject = 1'b0;
        while (!seek_done && guard < 300) begin
            @(posedge clk);
            @(negedge clk);
            guard++;
        end
        chk("R12", "flag after eject with step", int'(dir_reg[7]), 1);
        chk("R12", "cylinder", int'(cur_cyl), 74);
        do_seek(2'b00, 70, 1'b0, 70, 4, 1'b0, "R6");
        chk("R6", "flag stays after eject", int'(dir_reg[7]), 1);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R9: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_no_media();
        t_insert();
        t_eject();
        t_relative();
        t_saturate();
        t_busy();
        t_race();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule